// File: doc/BRIEF.md
# Dual-Slot Common-Interface Card Controller

This block sits between a small host register bus and two common-interface card slots that share one card bus. The host loads a 14-bit card address into two registers. It chooses a target slot and memory space in a shared bus-control register and then touches the data register. Each access to the data register runs one fixed-length read or write strobe cycle on the card bus. During that cycle the host side reports not-ready.

The same bus-control register also starts per-slot card resets, enables transport-stream pass-through for each slot and reports card presence for each slot. A reset request bit clears itself once the card reset has run for a set number of clocks. A change in card presence raises an interrupt. Reading the interrupt register acknowledges that interrupt. A second control register drives the two stream-output enables and the two tuner reset lines. A read-only register returns a fixed revision code.

Host accesses are accepted on a clock edge where `req` and `ready` are both high. For any register except data, `rdata` holds the result from the edge after acceptance. For a data read, `rdata` is valid once `ready` is high again.

Top module: `cicard_ctrl`

## Requirements
- R1: After reset, `ready` is 1, and `irq`, `card_sel`, `card_rd`, `card_wr`, `card_reset`, `ts_pass`, `ts_out_en`, `tuner_rst` and `rdata` are all 0. With no cards inserted (`card_cd_n` = 2'b11), bus control at offset 0x7 reads 0x03.
- R2: The address-low register (offset 0x4) drives `card_addr[6:0]` from its bits 7..1, and its bit 0 reads 0. The address-high register (offset 0x5) drives `card_addr[13:7]` from its bits 6..0, and its bit 7 reads 0.
- R3: A write to data (offset 0x6) drives `card_wr` for STROBE_LEN cycles, with `ready` low for the same cycles. During the write, `card_wdata` equals the written byte. `card_sel` is one-hot on the slot in bus-control bit 7 (0 = slot 0, 1 = slot 1). `card_space` follows bus-control bit 6 (1 = control/IO space, 0 = attribute memory).
- R4: A read of data (offset 0x6) drives `card_rd` for STROBE_LEN cycles. `rdata` then returns the `card_rdata` value sampled in the last strobe cycle.
- R5: Writing 1 to bus-control bit 5 resets slot 0, and writing 1 to bit 4 resets slot 1. The matching `card_reset` line stays high for RST_CYCLES cycles. The request bit reads 1 until the reset ends and then reads 0. Writing 0 to a request bit does not cut short a reset in progress.
- R6: Bus-control bit 3 drives `ts_pass[0]` and bit 2 drives `ts_pass[1]`. Bits 1 and 0 are read-only. They return the synchronized `card_cd_n[0]` and `card_cd_n[1]` (0 means a card is present), and writes to them are ignored.
- R7: Writing the interrupt register (offset 0x0) with bit 6 set enables the interrupt (for example 0x44). While the interrupt is enabled, any change of either presence bit sets `irq`. A read of offset 0x0 returns bit 6 = enable and bit 0 = pending, and clears `irq`. While the interrupt is disabled, presence changes do not raise `irq`.
- R8: The second bus-control register (offset 0x1) reads back all 8 bits. Bit 4 drives `ts_out_en[0]` and bit 5 drives `ts_out_en[1]`. Bit 3 drives `tuner_rst[0]` and bit 2 drives `tuner_rst[1]`, both active high.
- R9: Offset 0xF reads the REVISION parameter (default 0x2A), and writes to it are ignored. Reads of unmapped offsets return 0x00.
- R10: A request made while `ready` is low is ignored and changes no register. `card_addr` stays stable throughout a card cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Host access request |
| we | input | 1 | Host write (1) or read (0) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| ready | output | 1 | High when a request can be accepted |
| irq | output | 1 | Card-detect change interrupt |
| card_addr | output | 14 | Card address |
| card_wdata | output | 8 | Card write data |
| card_rdata | input | 8 | Card read data |
| card_sel | output | 2 | Per-slot select during a strobe cycle |
| card_space | output | 1 | 1 = control/IO space, 0 = attribute memory |
| card_rd | output | 1 | Card read strobe |
| card_wr | output | 1 | Card write strobe |
| card_reset | output | 2 | Per-slot card reset, active high |
| card_cd_n | input | 2 | Per-slot card detect, low when present |
| ts_pass | output | 2 | Per-slot stream pass-through enable |
| ts_out_en | output | 2 | Stream output enables |
| tuner_rst | output | 2 | Tuner reset lines, active high |

## Verification
The hardest case to reach from the ports is a host request that arrives while a card strobe cycle holds `ready` low. A normal host only issues requests when `ready` is high. The bench therefore raises `req` by hand in the middle of a data write and aims it at bus control with a value that would visibly change it. It then reads bus control back once the cycle has finished. A second hard case is a reset cancel written while a slot reset is still running. The bench issues that write a few cycles into a long reset, so the request bit can be seen still set afterwards.

// File: rtl/cicard_pkg.sv
package cicard_pkg;
   localparam logic [3:0] OFF_INTCTL  = 4'h0;
   localparam logic [3:0] OFF_BUSCTL2 = 4'h1;
   localparam logic [3:0] OFF_ADDRLO  = 4'h4;
   localparam logic [3:0] OFF_ADDRHI  = 4'h5;
   localparam logic [3:0] OFF_DATA    = 4'h6;
   localparam logic [3:0] OFF_BUSCTL  = 4'h7;
   localparam logic [3:0] OFF_REV     = 4'hF;

   localparam int NUM_SLOTS  = 2;
   localparam int CARD_AW    = 14;
   localparam int BC_SLOT    = 7;
   localparam int BC_SPACE   = 6;
   localparam int BC_RST_TOP = 5;   // slot s reset at BC_RST_TOP - s
   localparam int BC_TS_TOP  = 3;   // slot s pass-through at BC_TS_TOP - s
   localparam int BC_PRS_TOP = 1;   // slot s presence at BC_PRS_TOP - s
   localparam int IC_EN      = 6;
endpackage

// File: rtl/cicard_cycle.sv
module cicard_cycle #(
   parameter int STROBE_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_we,
   output logic busy,
   output logic last,
   output logic rd_stb,
   output logic wr_stb
);
   localparam int CW = $clog2(STROBE_LEN + 1);

   if (STROBE_LEN < 1) begin : g_bad_len
      $error("STROBE_LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          we_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
         we_q  <= 1'b0;
      end else if (!busy && start) begin
         busy  <= 1'b1;
         cnt_q <= CW'(STROBE_LEN - 1);
         we_q  <= start_we;
      end else if (busy) begin
         if (cnt_q == '0) busy <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last   = busy && (cnt_q == '0);
   assign rd_stb = busy && !we_q;
   assign wr_stb = busy && we_q;

   logic [CW:0] chk_run;
   always_ff @(posedge clk) begin
      if (!rst_n || !busy) chk_run <= '0;
      else                 chk_run <= chk_run + 1'b1;
   end

   AST_STROBE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (chk_run < (CW+1)'(STROBE_LEN))); // R3
endmodule

// File: rtl/cicard_slot_reset.sv
module cicard_slot_reset #(
   parameter int RST_CYCLES = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   localparam int CW = $clog2(RST_CYCLES + 1);

   if (RST_CYCLES < 1) begin : g_bad_rst
      $error("RST_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt_q  <= '0;
      end else if (!active && start) begin
         active <= 1'b1;
         cnt_q  <= CW'(RST_CYCLES - 1);
      end else if (active) begin
         if (cnt_q == '0) active <= 1'b0;
         else             cnt_q  <= cnt_q - 1'b1;
      end
   end

   logic [CW:0] chk_run;
   always_ff @(posedge clk) begin
      if (!rst_n || !active) chk_run <= '0;
      else                   chk_run <= chk_run + 1'b1;
   end

   AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (chk_run < (CW+1)'(RST_CYCLES))); // R5
endmodule

// File: rtl/cicard_cd_sync.sv
module cicard_cd_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] level,
   output logic         change
);
   if (STAGES < 2) begin : g_bad_stages
      $error("STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [0:STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k <= STAGES; k++) stage_q[k] <= '1;
      end else begin
         stage_q[0] <= din;
         for (int k = 1; k <= STAGES; k++) stage_q[k] <= stage_q[k-1];
      end
   end

   assign level  = stage_q[STAGES-1];
   assign change = |(stage_q[STAGES-1] ^ stage_q[STAGES]);
endmodule

// File: rtl/cicard_ctrl.sv
module cicard_ctrl
   import cicard_pkg::*;
#(
   parameter int         STROBE_LEN  = 4,
   parameter int         RST_CYCLES  = 20,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] REVISION    = 8'h2A
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req,
   input  logic        we,
   input  logic [3:0]  addr,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata,
   output logic        ready,
   output logic        irq,
   output logic [13:0] card_addr,
   output logic [7:0]  card_wdata,
   input  logic [7:0]  card_rdata,
   output logic [1:0]  card_sel,
   output logic        card_space,
   output logic        card_rd,
   output logic        card_wr,
   output logic [1:0]  card_reset,
   input  logic [1:0]  card_cd_n,
   output logic [1:0]  ts_pass,
   output logic [1:0]  ts_out_en,
   output logic [1:0]  tuner_rst
);
   localparam int LO_W = 7;
   localparam int HI_W = CARD_AW - LO_W;

   if (CARD_AW != 14) begin : g_bad_aw
      $error("card address layout assumes 14 bits");
   end

   logic                 acc, acc_wr, acc_rd;
   logic [LO_W-1:0]      addr_lo_q;
   logic [HI_W-1:0]      addr_hi_q;
   logic                 slot_q, space_q;
   logic [NUM_SLOTS-1:0] ts_q;
   logic [7:0]           ctl2_q;
   logic                 irq_en_q, irq_pend_q;
   logic [7:0]           wdata_q;
   logic [NUM_SLOTS-1:0] rst_start, rst_busy, pres;
   logic                 cd_change;
   logic                 cyc_busy, cyc_last, cyc_rd, cyc_wr;
   logic [7:0]           bc_val, rd_val;

   assign ready  = !cyc_busy;
   assign acc    = req && ready;
   assign acc_wr = acc && we;
   assign acc_rd = acc && !we;

   // card strobe engine
   cicard_cycle #(.STROBE_LEN(STROBE_LEN)) u_cycle (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (acc && (addr == OFF_DATA)),
      .start_we (we),
      .busy     (cyc_busy),
      .last     (cyc_last),
      .rd_stb   (cyc_rd),
      .wr_stb   (cyc_wr)
   );

   // card detect synchronizer
   cicard_cd_sync #(.W(NUM_SLOTS), .STAGES(SYNC_STAGES)) u_cd (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (card_cd_n),
      .level  (pres),
      .change (cd_change)
   );

   // per-slot reset engines and bus-control bit packing
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign rst_start[s] = acc_wr && (addr == OFF_BUSCTL) && wdata[BC_RST_TOP-s];

      cicard_slot_reset #(.RST_CYCLES(RST_CYCLES)) u_rst (
         .clk    (clk),
         .rst_n  (rst_n),
         .start  (rst_start[s]),
         .active (rst_busy[s])
      );

      assign card_reset[s]            = rst_busy[s];
      assign ts_pass[s]               = ts_q[s];
      assign card_sel[s]              = (cyc_rd || cyc_wr) && (slot_q == s[0]);
      assign bc_val[BC_RST_TOP-s]     = rst_busy[s];
      assign bc_val[BC_TS_TOP-s]      = ts_q[s];
      assign bc_val[BC_PRS_TOP-s]     = pres[s];
   end
   assign bc_val[BC_SLOT]  = slot_q;
   assign bc_val[BC_SPACE] = space_q;

   // register writes
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_lo_q <= '0;
         addr_hi_q <= '0;
         slot_q    <= 1'b0;
         space_q   <= 1'b0;
         ts_q      <= '0;
         ctl2_q    <= '0;
         irq_en_q  <= 1'b0;
         wdata_q   <= '0;
      end else if (acc_wr) begin
         unique case (addr)
            OFF_ADDRLO:  addr_lo_q <= wdata[7:1];
            OFF_ADDRHI:  addr_hi_q <= wdata[HI_W-1:0];
            OFF_BUSCTL2: ctl2_q    <= wdata;
            OFF_INTCTL:  irq_en_q  <= wdata[IC_EN];
            OFF_DATA:    wdata_q   <= wdata;
            OFF_BUSCTL: begin
               slot_q  <= wdata[BC_SLOT];
               space_q <= wdata[BC_SPACE];
               for (int s = 0; s < NUM_SLOTS; s++) ts_q[s] <= wdata[BC_TS_TOP-s];
            end
            default: ;
         endcase
      end
   end

   // interrupt: a new change wins over a same-cycle acknowledge
   always_ff @(posedge clk) begin
      if (!rst_n)                            irq_pend_q <= 1'b0;
      else if (cd_change && irq_en_q)        irq_pend_q <= 1'b1;
      else if (acc_rd && addr == OFF_INTCTL) irq_pend_q <= 1'b0;
   end
   assign irq = irq_pend_q && irq_en_q;

   // read mux
   always_comb begin
      unique case (addr)
         OFF_INTCTL:  rd_val = {1'b0, irq_en_q, 5'b0, irq_pend_q};
         OFF_BUSCTL2: rd_val = ctl2_q;
         OFF_ADDRLO:  rd_val = {addr_lo_q, 1'b0};
         OFF_ADDRHI:  rd_val = {1'b0, addr_hi_q};
         OFF_BUSCTL:  rd_val = bc_val;
         OFF_REV:     rd_val = REVISION;
         default:     rd_val = 8'h00;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                           rdata <= '0;
      else if (acc_rd && addr != OFF_DATA)  rdata <= rd_val;
      else if (cyc_last && cyc_rd)          rdata <= card_rdata;
   end

   assign card_addr  = {addr_hi_q, addr_lo_q};
   assign card_wdata = wdata_q;
   assign card_space = space_q;
   assign card_rd    = cyc_rd;
   assign card_wr    = cyc_wr;
   assign ts_out_en  = {ctl2_q[5], ctl2_q[4]};
   assign tuner_rst  = {ctl2_q[2], ctl2_q[3]};

   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(card_sel)); // R3
   AST_STROBE_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (card_rd || card_wr) |-> !ready); // R10
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_busy && !cyc_last) |=> $stable(card_addr)); // R10
   AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && addr == OFF_INTCTL && !cd_change) |=> !irq); // R7
endmodule

// File: tb/cicard_ctrl_tb.sv
module cicard_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int STROBE     = 4;
   localparam int RSTC       = 20;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0;
   logic [3:0]  addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        ready, irq;
   logic [13:0] card_addr;
   logic [7:0]  card_wdata;
   logic [7:0]  card_rdata = 8'h00;
   logic [1:0]  card_sel, card_reset, ts_pass, ts_out_en, tuner_rst;
   logic        card_space, card_rd, card_wr;
   logic [1:0]  card_cd_n = 2'b11;

   int tests = 0, fails = 0, cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cicard_ctrl #(.STROBE_LEN(STROBE), .RST_CYCLES(RSTC)) u_dut (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
      .rdata(rdata), .ready(ready), .irq(irq), .card_addr(card_addr),
      .card_wdata(card_wdata), .card_rdata(card_rdata), .card_sel(card_sel),
      .card_space(card_space), .card_rd(card_rd), .card_wr(card_wr),
      .card_reset(card_reset), .card_cd_n(card_cd_n), .ts_pass(ts_pass),
      .ts_out_en(ts_out_en), .tuner_rst(tuner_rst));

   // {check, we, addr, wdata, expected}
   localparam int NV = 11;
   localparam logic [21:0] VEC [NV] = '{
      {1'b0, 1'b1, 4'h4, 8'hAB, 8'h00},   // R2 address low
      {1'b1, 1'b0, 4'h4, 8'h00, 8'hAA},   // R2 bit 0 reads 0
      {1'b0, 1'b1, 4'h5, 8'hFF, 8'h00},   // R2 address high
      {1'b1, 1'b0, 4'h5, 8'h00, 8'h7F},   // R2 bit 7 reads 0
      {1'b0, 1'b1, 4'h1, 8'h3C, 8'h00},   // R8
      {1'b1, 1'b0, 4'h1, 8'h00, 8'h3C},   // R8 readback
      {1'b0, 1'b1, 4'h7, 8'hCC, 8'h00},   // R6 slot1, IO, both ts
      {1'b1, 1'b0, 4'h7, 8'h00, 8'hCF},   // R6 presence bits not written
      {1'b0, 1'b1, 4'hF, 8'h55, 8'h00},   // R9 write ignored
      {1'b1, 1'b0, 4'hF, 8'h00, 8'h2A},   // R9 revision
      {1'b1, 1'b0, 4'h2, 8'h00, 8'h00}    // R9 unmapped
   };

   task automatic check(input string req_tag, input int act, input int exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
      end
   endtask

   task automatic start_op(input logic w, input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      req = 1'b1; we = w; addr = a; wdata = d;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   task automatic host_op(input logic w, input logic [3:0] a, input logic [7:0] d,
                          output logic [7:0] r);
      start_op(w, a, d);
      while (!ready) @(negedge clk);
      r = rdata;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      logic [7:0] r;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 reset state
      check("R1 ready", ready, 1);
      check("R1 irq", irq, 0);
      check("R1 card_sel", card_sel, 0);
      check("R1 strobes", {card_rd, card_wr}, 0);
      check("R1 card_reset", card_reset, 0);
      check("R1 ts/tuner", {ts_pass, ts_out_en, tuner_rst}, 0);
      check("R1 rdata", rdata, 0);
      host_op(1'b0, 4'h7, 8'h00, r);
      check("R1 busctl", r, 8'h03);

      // table walk: R2 R6 R8 R9
      for (int i = 0; i < NV; i++) begin
         host_op(VEC[i][20], VEC[i][19:16], VEC[i][15:8], r);
         if (VEC[i][21]) check($sformatf("R2/R6/R8/R9 vector %0d", i), r, VEC[i][7:0]);
      end
      check("R2 card_addr", card_addr, {7'h7F, 7'h55});
      check("R6 ts_pass", ts_pass, 2'b11);
      check("R8 ts_out_en", ts_out_en, 2'b11);
      check("R8 tuner_rst", tuner_rst, 2'b11);
      host_op(1'b1, 4'h1, 8'h08, r);
      check("R8 tuner_rst one", tuner_rst, 2'b01);
      check("R8 ts_out_en off", ts_out_en, 2'b00);

      // R3 card write cycle on slot 1, IO space
      start_op(1'b1, 4'h6, 8'h96);
      check("R3 ready low", ready, 0);
      check("R3 card_sel", card_sel, 2'b10);
      check("R3 card_space", card_space, 1);
      check("R3 card_wdata", card_wdata, 8'h96);
      check("R3 no read strobe", card_rd, 0);
      n = 0;
      while (card_wr) begin n++; @(negedge clk); end
      check("R3 strobe length", n, STROBE);
      check("R3 ready back", ready, 1);

      // R10 request during a busy cycle is dropped
      start_op(1'b1, 4'h6, 8'h11);
      req = 1'b1; we = 1'b1; addr = 4'h7; wdata = 8'h00;
      @(posedge clk);
      @(negedge clk);
      req = 1'b0; we = 1'b0;
      while (!ready) @(negedge clk);
      host_op(1'b0, 4'h7, 8'h00, r);
      check("R10 busctl unchanged", r, 8'hCF);

      // R4 card read cycle on slot 0, attribute memory
      host_op(1'b1, 4'h7, 8'h08, r);
      card_rdata = 8'h5A;
      start_op(1'b0, 4'h6, 8'h00);
      check("R4 card_rd", card_rd, 1);
      check("R4 card_sel", card_sel, 2'b01);
      check("R4 card_space", card_space, 0);
      n = 0;
      while (card_rd) begin n++; @(negedge clk); end
      check("R4 strobe length", n, STROBE);
      check("R4 rdata", rdata, 8'h5A);
      card_rdata = 8'h00;

      // R5 slot 0 reset duration
      start_op(1'b1, 4'h7, 8'h28);
      check("R5 slot1 idle", card_reset[1], 0);
      n = 0;
      while (card_reset[0]) begin n++; @(negedge clk); end
      check("R5 reset length", n, RSTC);
      host_op(1'b0, 4'h7, 8'h00, r);
      check("R5 bit5 cleared", r, 8'h0B);

      // R5 slot 1 readback and no cancel
      host_op(1'b1, 4'h7, 8'h18, r);
      host_op(1'b0, 4'h7, 8'h00, r);
      check("R5 bit4 busy", r, 8'h1B);
      host_op(1'b1, 4'h7, 8'h08, r);
      host_op(1'b0, 4'h7, 8'h00, r);
      check("R5 not cancelled", r, 8'h1B);
      check("R5 card_reset1", card_reset, 2'b10);
      while (card_reset[1]) @(negedge clk);
      host_op(1'b0, 4'h7, 8'h00, r);
      check("R5 bit4 cleared", r, 8'h0B);

      // R7 interrupt enabled
      host_op(1'b1, 4'h0, 8'h44, r);
      check("R7 no irq yet", irq, 0);
      card_cd_n = 2'b10;
      repeat (5) @(negedge clk);
      check("R7 irq set", irq, 1);
      host_op(1'b0, 4'h0, 8'h00, r);
      check("R7 status", r, 8'h41);
      check("R7 irq cleared", irq, 0);
      host_op(1'b0, 4'h7, 8'h00, r);
      check("R6 presence slot0", r, 8'h09);

      // R7 interrupt disabled
      host_op(1'b1, 4'h0, 8'h00, r);
      card_cd_n = 2'b00;
      repeat (5) @(negedge clk);
      check("R7 disabled irq", irq, 0);
      host_op(1'b0, 4'h0, 8'h00, r);
      check("R7 disabled status", r, 8'h00);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule